// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block decides which of N maskable interrupt sources a small CPU core services next. Each source keeps a pending flag, a mask bit and a one-bit priority level (0 = high, 1 = low). A source competes only when it is pending and unmasked, and the core's global enable must be on. While a high-priority handler runs, the in-service level bit is 0 and low-priority sources cannot nest.

Among the sources that compete, high-priority ones beat low-priority ones. Within a level, the lowest source index wins. When a source is accepted, the block emits a one-cycle acknowledge with the source index and clears that source's pending flag. It then pushes the status word and the program counter to a stack interface through a valid/ready handshake. After both pushes it clears the global enable, loads the in-service level from the winner's priority bit, and issues a one-cycle branch request carrying the vector index. A return pulse restores the enable and in-service bits from values popped by the core.

Top module: `irq_arbiter`

## Requirements
- R1: A source can be acknowledged only while its pending flag is 1 and its mask bit is 0. A pending source that is masked stays pending.
- R2: No acknowledge occurs while the global enable (`ie_o`) is 0.
- R3: While `isp_o` is 0, a source whose priority bit is 1 is never acknowledged.
- R4: When several sources compete, any source with priority bit 0 wins over all sources with priority bit 1. Within one level, the lowest index wins.
- R5: After `ack`, the block pushes tag 2'b01 (status word, zero-extended `psw_in`) first and then tag 2'b10 (`pc_in`). The next cycle it raises `branch_valid` with `branch_vec` equal to the acknowledged index. In that cycle `ie_o` is 0 and `isp_o` equals the winner's priority bit.
- R6: While `push_valid` is 1 and `push_ready` is 0, `push_valid`, `push_tag` and `push_data` hold.
- R7: A source that cannot be acknowledged stays pending. It is acknowledged once the enable, mask or in-service conditions allow it.
- R8: A high-priority winner is acknowledged in the first cycle in which it is eligible. A low-priority winner is acknowledged one cycle later.
- R9: On the clock edge that ends the `ack` cycle, only the winner's pending flag is cleared. The other pending flags keep their values. A `req_set` bit sets its flag and takes precedence over the clear.
- R10: A `reti` pulse loads `ie_o` from `reti_ie` and `isp_o` from `reti_isp`. `ie_set` and `ie_clr` set and clear `ie_o` when no `reti` or push completion is present.
- R11: After reset, all pending flags are 0, all mask bits are 1, all priority bits are 1, `ie_o` is 0 and `isp_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | N_SRC | Per-source request pulses that set pending flags |
| mask_wr | input | 1 | Write strobe for the mask bits |
| mask_wdata | input | N_SRC | New mask bits (1 = masked) |
| prio_wr | input | 1 | Write strobe for the priority bits |
| prio_wdata | input | N_SRC | New priority bits (0 = high) |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| psw_in | input | PSW_W | Status word to save |
| pc_in | input | PC_W | Program counter to save |
| push_valid | output | 1 | Stack push request |
| push_tag | output | 2 | 01 = status word, 10 = program counter |
| push_data | output | PC_W | Data pushed |
| push_ready | input | 1 | Stack accepts push |
| ack | output | 1 | One-cycle acknowledge |
| ack_vec | output | VEC_W | Index of acknowledged source |
| branch_valid | output | 1 | One-cycle branch request |
| branch_vec | output | VEC_W | Vector index for branch |
| reti | input | 1 | Return-from-interrupt pulse |
| reti_ie | input | 1 | Restored global enable |
| reti_isp | input | 1 | Restored in-service level |
| ie_o | output | 1 | Global enable |
| isp_o | output | 1 | In-service level (0 = high-priority handler active) |
| req_pend | output | N_SRC | Pending flags |

## Verification
The bound checker watches every cycle for these properties. An acknowledged source is pending, unmasked and enabled. A low-level winner never appears while a high-level source competes or while `isp_o` is 0. The acknowledge clears the winner's flag. The status word is pushed first, and pushes hold under back-pressure. Enable is off at branch time. Only the bench scenarios show the rest, using an exhaustive sweep of pending, mask, priority and in-service patterns on a four-source build. These cover the exact winner index and the one-cycle latency difference between levels. They also cover the pushed data values, the branch vector, the restore by `reti`, and a masked request being serviced after it is unmasked.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int PC_W  = 16,
  parameter int PSW_W = 8,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_set,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             prio_wr,
  input  logic [N_SRC-1:0] prio_wdata,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic [PSW_W-1:0] psw_in,
  input  logic [PC_W-1:0]  pc_in,
  output logic             push_valid,
  output logic [1:0]       push_tag,
  output logic [PC_W-1:0]  push_data,
  input  logic             push_ready,
  output logic             ack,
  output logic [VEC_W-1:0] ack_vec,
  output logic             branch_valid,
  output logic [VEC_W-1:0] branch_vec,
  input  logic             reti,
  input  logic             reti_ie,
  input  logic             reti_isp,
  output logic             ie_o,
  output logic             isp_o,
  output logic [N_SRC-1:0] req_pend
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PSW, S_PC, S_BR} st_t;

  st_t              state;
  logic [N_SRC-1:0] req_q, mask_q, prio_q;
  logic [VEC_W-1:0] vec_r;
  logic             prio_r, ie_q, isp_q;
  logic [N_SRC-1:0] elig_hi, elig_lo;
  logic             hi_any, lo_any;
  logic [VEC_W-1:0] hi_idx, lo_idx, win_idx;

  assign elig_hi = req_q & ~mask_q & ~prio_q;
  assign elig_lo = req_q & ~mask_q & prio_q & {N_SRC{isp_q}};

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) begin
        hi_any = 1'b1;
        hi_idx = VEC_W'(i);
      end
      if (elig_lo[i]) begin
        lo_any = 1'b1;
        lo_idx = VEC_W'(i);
      end
    end
  end

  assign win_idx = hi_any ? hi_idx : lo_idx;
  assign ack = ie_q && ((state == S_IDLE && hi_any) ||
                        (state == S_WAIT && (hi_any || lo_any)));
  assign ack_vec = win_idx;

  assign push_valid   = (state == S_PSW) || (state == S_PC);
  assign push_tag     = (state == S_PC) ? 2'b10 : 2'b01;
  assign push_data    = (state == S_PC) ? pc_in : PC_W'(psw_in);
  assign branch_valid = (state == S_BR);
  assign branch_vec   = vec_r;
  assign ie_o         = ie_q;
  assign isp_o        = isp_q;
  assign req_pend     = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      req_q  <= '0;
      mask_q <= '1;
      prio_q <= '1;
      ie_q   <= 1'b0;
      isp_q  <= 1'b1;
      vec_r  <= '0;
      prio_r <= 1'b1;
    end else begin
      if (ack) req_q <= (req_q & ~(N_SRC'(1) << win_idx)) | req_set;
      else     req_q <= req_q | req_set;
      if (mask_wr) mask_q <= mask_wdata;
      if (prio_wr) prio_q <= prio_wdata;

      if (state == S_PC && push_ready) begin
        ie_q  <= 1'b0;
        isp_q <= prio_r;
      end else if (reti) begin
        ie_q  <= reti_ie;
        isp_q <= reti_isp;
      end else if (ie_clr) begin
        ie_q <= 1'b0;
      end else if (ie_set) begin
        ie_q <= 1'b1;
      end

      if (ack) begin
        vec_r  <= win_idx;
        prio_r <= prio_q[win_idx];
      end

      unique case (state)
        S_IDLE: if (ack) state <= S_PSW;
                else if (ie_q && lo_any) state <= S_WAIT;
        S_WAIT: state <= ack ? S_PSW : S_IDLE;
        S_PSW:  if (push_ready) state <= S_PC;
        S_PC:   if (push_ready) state <= S_BR;
        S_BR:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_SRC = 8,
  parameter int PC_W  = 16,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ie_o,
  input logic             isp_o,
  input logic [N_SRC-1:0] req_pend,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] prio_q,
  input logic [N_SRC-1:0] req_set,
  input logic             push_valid,
  input logic             push_ready,
  input logic [1:0]       push_tag,
  input logic [PC_W-1:0]  push_data,
  input logic             branch_valid
);

  AST_ACK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (req_pend[ack_vec] && !mask_q[ack_vec])); // R1
  AST_ACK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ie_o); // R2
  AST_NO_LOW_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !isp_o) |-> !prio_q[ack_vec]); // R3
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && prio_q[ack_vec]) |-> ((req_pend & ~mask_q & ~prio_q) == '0)); // R4
  AST_PSW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_valid) |-> (push_tag == 2'b01)); // R5
  AST_BRANCH_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |-> !ie_o); // R5
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_tag) && $stable(push_data))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_set[ack_vec]) |=> !req_pend[$past(ack_vec)]); // R9

endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC), .PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_vec(ack_vec), .ie_o(ie_o),
  .isp_o(isp_o), .req_pend(req_pend), .mask_q(mask_q), .prio_q(prio_q),
  .req_set(req_set), .push_valid(push_valid), .push_ready(push_ready),
  .push_tag(push_tag), .push_data(push_data), .branch_valid(branch_valid)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;
  localparam int N = 4;
  localparam int VW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_set = '0, mask_wdata = '0, prio_wdata = '0;
  logic mask_wr = 0, prio_wr = 0, ie_set = 0, ie_clr = 0;
  logic [7:0] psw_in = 8'hA5;
  logic [15:0] pc_in = 16'h1234;
  logic push_valid, push_ready = 1, ack, branch_valid, ie_o, isp_o;
  logic [1:0] push_tag;
  logic [15:0] push_data;
  logic [VW-1:0] ack_vec, branch_vec;
  logic reti = 0, reti_ie = 0, reti_isp = 0;
  logic [N-1:0] req_pend;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_arbiter #(.N_SRC(N), .PC_W(16), .PSW_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .prio_wr(prio_wr), .prio_wdata(prio_wdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .psw_in(psw_in), .pc_in(pc_in),
    .push_valid(push_valid), .push_tag(push_tag), .push_data(push_data),
    .push_ready(push_ready), .ack(ack), .ack_vec(ack_vec),
    .branch_valid(branch_valid), .branch_vec(branch_vec), .reti(reti),
    .reti_ie(reti_ie), .reti_isp(reti_isp), .ie_o(ie_o), .isp_o(isp_o),
    .req_pend(req_pend));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic do_reset();
    nclk(); rst_n = 0;
    nclk(); rst_n = 1;
  endtask

  function automatic int winner(input logic [N-1:0] r, m, p, input logic isp, output bit hi);
    logic [N-1:0] e = r & ~m;
    hi = 0;
    for (int i = 0; i < N; i++) if (e[i] && !p[i]) begin hi = 1; return i; end
    if (isp) for (int i = 0; i < N; i++) if (e[i] && p[i]) return i;
    return -1;
  endfunction

  task automatic follow(input int w, input logic pw, input logic [N-1:0] r);
    nclk();
    chk(push_valid && push_tag == 2'b01, "R5 psw tag", push_tag, 1);
    chk(push_data == 16'(psw_in), "R5 psw data", push_data, psw_in);
    chk(req_pend == (r & ~(N'(1) << w)), "R9 flags", req_pend, r & ~(N'(1) << w));
    nclk();
    chk(push_valid && push_tag == 2'b10, "R5 pc tag", push_tag, 2);
    chk(push_data == pc_in, "R5 pc data", push_data, pc_in);
    nclk();
    chk(branch_valid && branch_vec == VW'(w), "R5 branch vec", branch_vec, w);
    chk(!ie_o && isp_o == pw, "R5 ie/isp", {ie_o, isp_o}, {1'b0, pw});
  endtask

  task automatic run_case(input logic [N-1:0] r, m, p, input logic isp);
    bit hi;
    int w;
    do_reset();
    mask_wr = 1; mask_wdata = m; prio_wr = 1; prio_wdata = p;
    reti = 1; reti_ie = 0; reti_isp = isp;
    nclk();
    mask_wr = 0; prio_wr = 0; reti = 0; req_set = r;
    nclk();
    req_set = '0; ie_set = 1;
    chk(!ack && req_pend == r, "R2 no ack while ie=0", {ack, req_pend}, {1'b0, r});
    nclk();
    ie_set = 0;
    w = winner(r, m, p, isp, hi);
    if (w < 0) begin
      chk(!ack, "R1/R3 none eligible", ack, 0);
      nclk();
      chk(!ack && req_pend == r, "R7 stays pending", {ack, req_pend}, {1'b0, r});
      return;
    end
    if (hi) begin
      chk(ack && ack_vec == VW'(w), "R4/R8 high ack", {ack, ack_vec}, {1'b1, VW'(w)});
    end else begin
      chk(!ack, "R8 low delayed", ack, 0);
      nclk();
      chk(ack && ack_vec == VW'(w), "R3/R4/R8 low ack", {ack, ack_vec}, {1'b1, VW'(w)});
    end
    follow(w, p[w], r);
  endtask

  initial begin
    nclk(); nclk(); rst_n = 1;
    chk(req_pend == 0 && !ie_o && isp_o && !ack && !push_valid && !branch_valid,
        "R11 reset", {req_pend, ie_o, isp_o}, 1);
    req_set = '1; nclk(); req_set = '0; ie_set = 1; nclk(); ie_set = 0; nclk(); nclk();
    chk(!ack && req_pend == '1, "R11 masked after reset", {ack, req_pend}, 4'hF);

    for (int isp = 0; isp < 2; isp++)
      for (int p = 0; p < 16; p++)
        for (int m = 0; m < 16; m++)
          for (int r = 0; r < 16; r++)
            run_case(N'(r), N'(m), N'(p), 1'(isp));

    // R6 back-pressure, then R10 restore, then R7 late unmask
    do_reset();
    mask_wr = 1; mask_wdata = 4'b0111; prio_wr = 1; prio_wdata = 4'b0000; push_ready = 0;
    nclk(); mask_wr = 0; prio_wr = 0; req_set = 4'b1010;
    nclk(); req_set = 0; ie_set = 1;
    nclk(); ie_set = 0;
    chk(ack && ack_vec == 2'd3, "R1 unmasked wins", ack_vec, 3);
    for (int k = 0; k < 3; k++) begin
      nclk();
      chk(push_valid && push_tag == 2'b01 && push_data == 16'h00A5, "R6 hold", push_tag, 1);
    end
    push_ready = 1; nclk();
    chk(push_tag == 2'b10, "R6 advance", push_tag, 2);
    nclk();
    chk(branch_valid && branch_vec == 2'd3 && !isp_o, "R5 branch hi", branch_vec, 3);
    reti = 1; reti_ie = 1; reti_isp = 1; nclk(); reti = 0;
    chk(ie_o && isp_o, "R10 reti restore", {ie_o, isp_o}, 3);
    chk(!ack && req_pend == 4'b0010, "R7 masked pending", req_pend, 2);
    mask_wr = 1; mask_wdata = 4'b0000; nclk(); mask_wr = 0;
    chk(ack && ack_vec == 2'd1, "R7 ack after unmask", ack_vec, 1);
    nclk(); nclk(); nclk(); nclk();
    ie_set = 1; nclk(); ie_set = 0;
    chk(ie_o, "R10 ie_set", ie_o, 1);
    ie_clr = 1; ie_set = 1; nclk(); ie_clr = 0; ie_set = 0;
    chk(!ie_o, "R10 ie_clr wins", ie_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule